// File: doc/BRIEF.md
# Three-Wire Amplifier Control Register Slave

This block is a serial slave that holds the control word of a programmable amplifier. A host reaches it over three wires: an active-low chip select, a serial clock and a single half-duplex data pin. The data pin is split at the block edge into an input, an output and an output enable, which the pad ring combines. Each access is a fixed 24-bit frame. The first 8 bits are a command, and its most significant bit picks read or write. The next 16 bits are the data word.

A write decodes the data word into four amplifier settings: the bandwidth filter, the auxiliary output power mode, the preamp gain range and the attenuation step. The new settings take effect only when the frame is complete. Codes that the amplifier cannot use are clamped to the nearest legal setting. A read returns the current settings on the data pin during the data phase.

All three serial inputs are synchronised into the system clock, and serial clock edges are detected by oversampling. The serial clock must therefore run well below the system clock.

Top module: `vga_spi_ctrl`

## Requirements
- R1: After reset the filter code is 6 (full bandwidth), aux_off_o is 0 (full power), hi_gain_o is 0 (low gain), atten_o is 0 (0 dB), and sdio_oe_o is 0.
- R2: While cs_ni is low, sdio_i is sampled on each rising edge of sclk_i, most significant bit first. A frame whose command bit 7 is 0 is a write. Its data word maps as follows: bits [3:0] give the attenuation step, bits [6:4] give the filter code, bit 7 selects high gain, bit 8 disables the auxiliary output, and bits [15:9] are ignored. The settings change only once the 24th bit has been sampled.
- R3: A frame whose command bit 7 is 1 is a read. After each falling edge of sclk_i in the data phase, sdio_oe_o is 1 and sdio_o carries the next bit of the word {7'b0, aux_off, hi_gain, filter[2:0], atten[3:0]}, most significant bit first. A read leaves the settings unchanged.
- R4: A frame ended by raising cs_ni before 24 bits leaves the settings unchanged.
- R5: Clock edges after the 24th bit, within the same chip-select assertion, are ignored. sdio_oe_o is 0 from the 24th rising edge on.
- R6: Edges on sclk_i while cs_ni is high do not advance the bit position. The next frame is decoded from its first bit.
- R7: sdio_oe_o is 0 whenever cs_ni is high, during the whole of a write frame, and during the command phase of a read.
- R8: A written attenuation code above 9 is stored as 9.
- R9: Filter codes 0 to 6 select 20, 100, 200, 350, 650 and 750 MHz and full bandwidth, in that order. A written code of 7 is stored as 6.
- R10: Command bits [6:0] have no effect on either writes or reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe_o | output | 1 | Data pin output enable |
| filt_sel_o | output | 3 | Bandwidth filter code |
| aux_off_o | output | 1 | Auxiliary output disabled |
| hi_gain_o | output | 1 | Preamp high-gain range |
| atten_o | output | 4 | Attenuation step, 2 dB each |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and an attenuation limit of 9. It drives the serial clock at sixteen system clocks per period, so that each detected edge settles well before the next one. With these values the clamp boundary at codes 9 and 10 can be reached, along with filter code 7. Frames aborted after the command phase and part of the data phase are covered, as are frames that run 6 to 8 bits past the end. A behavioural model of the settings is compared with the outputs on every idle clock, and each read bit is compared before the rising edge that would sample it.

// File: rtl/vga_spi_pkg.sv
package vga_spi_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 16;
  localparam int ATT_W  = 4;
  localparam int FILT_W = 3;

  typedef enum logic [FILT_W-1:0] {
    FILT_20M  = 3'd0,
    FILT_100M = 3'd1,
    FILT_200M = 3'd2,
    FILT_350M = 3'd3,
    FILT_650M = 3'd4,
    FILT_750M = 3'd5,
    FILT_FULL = 3'd6
  } filt_e;

  // packed MSB first: bit 8 aux_off, bit 7 hi_gain, bits 6:4 filt, bits 3:0 atten
  typedef struct packed {
    logic             aux_off;
    logic             hi_gain;
    filt_e            filt;
    logic [ATT_W-1:0] atten;
  } amp_cfg_t;

  localparam int CFG_W = $bits(amp_cfg_t);
endpackage

// File: rtl/vga_spi_sync.sv
module vga_spi_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= RST_VAL;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/vga_spi_frame.sv
module vga_spi_frame
  import vga_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(FRAME_W);

  logic              sclk_q, rd_q;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic [DATA_W-1:0] sh_q;
  logic              rise, fall;

  assign rise = cs_act_i & sclk_i & ~sclk_q;
  assign fall = cs_act_i & ~sclk_i & sclk_q;
  assign idx  = CNT_LAST - cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      rd_q      <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_word_o <= '0;
      sdo_o     <= 1'b0;
      oe_o      <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      wr_en_o <= 1'b0;
      if (!cs_act_i) begin
        cnt_q <= '0;
        oe_o  <= 1'b0;
      end else begin
        if (rise && cnt_q < CNT_DONE) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0) rd_q <= sdi_i;          // command MSB = read flag
          if (cnt_q >= CNT_CMD) sh_q <= {sh_q[DATA_W-2:0], sdi_i};
          if (cnt_q == CNT_LAST) begin
            oe_o <= 1'b0;
            if (!rd_q) begin
              wr_en_o   <= 1'b1;
              wr_word_o <= {sh_q[DATA_W-2:0], sdi_i};
            end
          end
        end
        if (fall && rd_q && cnt_q >= CNT_CMD && cnt_q < CNT_DONE) begin
          oe_o  <= 1'b1;
          sdo_o <= rd_word_i[idx[IDX_W-1:0]];
        end
      end
    end
  end
endmodule

// File: rtl/vga_spi_regs.sv
module vga_spi_regs
  import vga_spi_pkg::*;
#(
  parameter int ATT_MAX = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_word_i,
  output amp_cfg_t          cfg_o
);
  localparam amp_cfg_t CFG_RST = '{aux_off: 1'b0, hi_gain: 1'b0,
                                   filt: FILT_FULL, atten: '0};
  localparam logic [ATT_W-1:0] ATT_LIM = ATT_W'(ATT_MAX);

  amp_cfg_t nxt;

  always_comb begin
    nxt = amp_cfg_t'(wr_word_i[CFG_W-1:0]);
    if (nxt.atten > ATT_LIM) nxt.atten = ATT_LIM;
    if (&wr_word_i[ATT_W +: FILT_W]) nxt.filt = FILT_FULL;  // unused code
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cfg_o <= CFG_RST;
    else if (wr_en_i) cfg_o <= nxt;
endmodule

// File: rtl/vga_spi_ctrl.sv
module vga_spi_ctrl
  import vga_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ATT_MAX     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe_o,
  output logic [FILT_W-1:0] filt_sel_o,
  output logic             aux_off_o,
  output logic             hi_gain_o,
  output logic [ATT_W-1:0] atten_o
);
  logic [2:0]        sync_q;
  logic              wr_en;
  logic [DATA_W-1:0] wr_word;
  amp_cfg_t          cfg;

  vga_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdio_i}),
    .q_o   (sync_q)
  );

  vga_spi_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (~sync_q[2]),
    .sclk_i   (sync_q[1]),
    .sdi_i    (sync_q[0]),
    .rd_word_i(DATA_W'(cfg)),
    .wr_en_o  (wr_en),
    .wr_word_o(wr_word),
    .sdo_o    (sdio_o),
    .oe_o     (sdio_oe_o)
  );

  vga_spi_regs #(.ATT_MAX(ATT_MAX)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_word_i(wr_word),
    .cfg_o    (cfg)
  );

  assign filt_sel_o = cfg.filt;
  assign aux_off_o  = cfg.aux_off;
  assign hi_gain_o  = cfg.hi_gain;
  assign atten_o    = cfg.atten;
endmodule

// File: rtl/vga_spi_ctrl_chk.sv
module vga_spi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sdio_oe_o,
  input logic [2:0] filt_sel_o,
  input logic       aux_off_o,
  input logic       hi_gain_o,
  input logic [3:0] atten_o
);
  // chip select idle long enough to pass the synchroniser: pin released
  p_oe_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdio_oe_o);

  // no settings change without an active frame
  p_cfg_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |=>
      ($stable(atten_o) && $stable(filt_sel_o) && $stable(aux_off_o) && $stable(hi_gain_o)));

  p_atten_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atten_o <= 4'd9);

  p_filt_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_sel_o != 3'd7);
endmodule

bind vga_spi_ctrl vga_spi_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sdio_oe_o (sdio_oe_o),
  .filt_sel_o(filt_sel_o),
  .aux_off_o (aux_off_o),
  .hi_gain_o (hi_gain_o),
  .atten_o   (atten_o)
);

// File: tb/vga_spi_ctrl_tb.sv
module vga_spi_ctrl_tb;
  localparam int H = 8;  // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic       sdio_o, sdio_oe_o, aux_off_o, hi_gain_o;
  logic [2:0] filt_sel_o;
  logic [3:0] atten_o;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // behavioural model of the settings
  logic [3:0] m_att = 4'd0;
  logic [2:0] m_filt = 3'd6;
  logic       m_hg = 1'b0, m_aux = 1'b0;

  always #5 clk = ~clk;

  vga_spi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .filt_sel_o(filt_sel_o),
    .aux_off_o(aux_off_o), .hi_gain_o(hi_gain_o), .atten_o(atten_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_word();
    return {7'b0, m_aux, m_hg, m_filt, m_att};
  endfunction

  function automatic void m_write(input logic [15:0] d);
    m_att  = (d[3:0] > 4'd9) ? 4'd9 : d[3:0];
    m_filt = (d[6:4] == 3'd7) ? 3'd6 : d[6:4];
    m_hg   = d[7];
    m_aux  = d[8];
  endfunction

  // settings compared against the model on every idle clock (R2 R4 R6)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check({aux_off_o, hi_gain_o, filt_sel_o, atten_o} === {m_aux, m_hg, m_filt, m_att},
            "R2 settings vs model", {aux_off_o, hi_gain_o, filt_sel_o, atten_o},
            {m_aux, m_hg, m_filt, m_att});
      check(sdio_oe_o === 1'b0, "R7 oe idle", sdio_oe_o, 0);
    end
  end

  task automatic frame(input logic [7:0] cmd, input logic [15:0] dat, input int nbits);
    logic [23:0] bits;
    logic [15:0] exp_rd;
    bits   = {cmd, dat};
    exp_rd = m_word();
    cmp_en = 1'b0;
    @(negedge clk) cs_ni = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdio_i = (i < 24) ? bits[23 - i] : i[0];
      repeat (H) @(negedge clk);
      if (cmd[7] && i >= 8 && i < 24) begin
        check(sdio_oe_o === 1'b1, "R3 oe in read data phase", sdio_oe_o, 1);
        check(sdio_o === exp_rd[23 - i], "R3 read bit", sdio_o, exp_rd[23 - i]);
      end else if (i >= 24) begin
        check(sdio_oe_o === 1'b0, "R5 oe after frame", sdio_oe_o, 0);
      end else begin
        check(sdio_oe_o === 1'b0, "R7 oe write or command", sdio_oe_o, 0);
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    check(sdio_oe_o === 1'b0, "R5 oe at frame end", sdio_oe_o, 0);
    cs_ni = 1'b1;
    repeat (2 * H) @(negedge clk);
    if (!cmd[7] && nbits >= 24) m_write(dat);
    cmp_en = 1'b1;
  endtask

  task automatic expect_cfg(input string req, input logic [2:0] f, input logic [3:0] a,
                            input logic hg, input logic ax);
    @(negedge clk);
    check({aux_off_o, hi_gain_o, filt_sel_o, atten_o} === {ax, hg, f, a}, req,
          {aux_off_o, hi_gain_o, filt_sel_o, atten_o}, {ax, hg, f, a});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_cfg("R1 reset settings", 3'd6, 4'd0, 1'b0, 1'b0);
    check(sdio_oe_o === 1'b0, "R1 reset oe", sdio_oe_o, 0);
    cmp_en = 1'b1;

    frame(8'h00, 16'h01A5, 24);
    expect_cfg("R2 write fields", 3'd2, 4'd5, 1'b1, 1'b1);
    frame(8'h80, 16'hFFFF, 24);  // R3 read, data pin content ignored
    expect_cfg("R3 read leaves settings", 3'd2, 4'd5, 1'b1, 1'b1);

    frame(8'h7F, 16'hFE37, 24);  // R10 low command bits ignored, R2 high data bits ignored
    expect_cfg("R10 write with cmd 7F", 3'd3, 4'd7, 1'b0, 1'b0);
    frame(8'hFF, 16'h0000, 24);  // R10 read with cmd FF
    expect_cfg("R10 read with cmd FF", 3'd3, 4'd7, 1'b0, 1'b0);

    frame(8'h00, 16'h0009, 24);
    expect_cfg("R8 atten 9 kept", 3'd0, 4'd9, 1'b0, 1'b0);
    frame(8'h00, 16'h000A, 24);
    expect_cfg("R8 atten 10 clamped", 3'd0, 4'd9, 1'b0, 1'b0);
    frame(8'h00, 16'h00FF, 24);
    expect_cfg("R8 R9 atten 15 filt 7 clamped", 3'd6, 4'd9, 1'b1, 1'b0);
    frame(8'h80, 16'h0000, 24);

    frame(8'h00, 16'h0123, 20);  // R4 aborted in data phase
    expect_cfg("R4 abort in data phase", 3'd6, 4'd9, 1'b1, 1'b0);
    frame(8'h00, 16'h0000, 8);   // R4 aborted after command
    expect_cfg("R4 abort after command", 3'd6, 4'd9, 1'b1, 1'b0);

    frame(8'h00, 16'h0142, 32);  // R5 extra clocks after frame
    expect_cfg("R5 extra clocks ignored", 3'd4, 4'd2, 1'b0, 1'b1);
    frame(8'h80, 16'h0000, 30);  // R5 read with trailing clocks

    // R6 clock edges with chip select high
    cmp_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      sdio_i = k[0];
      repeat (H) @(negedge clk); sclk = 1'b1;
      repeat (H) @(negedge clk); sclk = 1'b0;
    end
    frame(8'h00, 16'h0061, 24);
    expect_cfg("R6 frame after idle clocks", 3'd6, 4'd1, 1'b0, 1'b0);

    for (int f = 0; f < 7; f++) begin
      frame(8'h00, 16'(f << 4) | 16'h0003, 24);
      expect_cfg("R9 filter code", 3'(f), 4'd3, 1'b0, 1'b0);
    end
    frame(8'h80, 16'h0000, 24);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule